// File: doc/BRIEF.md
# Masked CAM Routing Decision Unit

This block makes the output-port decision for one switch node of a parallel interconnection network. Each cycle it may take one routing key, which is normally built by concatenating the packet's destination field with the current-node field. It compares the key against a small table in one step. Every table entry stores a pattern, its own don't-care mask and a valid flag. A fixed-priority resolver keeps exactly one of the matching entries. The index of that entry selects a port number from a separate port table. When no entry matches, the block reports a miss and returns a programmable default port.

A host write port loads whole entries (pattern, mask, valid, port) and the default port. Entry storage is treated as dynamic storage that needs periodic rewriting. A background engine walks the entries round-robin and rewrites each one with its current value. The engine only uses write slots that the host leaves free, and it never holds back a lookup.

The pipeline has two stages. Stage one compares the key against the table and takes a snapshot of the port table. Stage two resolves priority, selects the port and registers the result. A decision leaves the block two clock edges after its key enters, and a new key can enter every cycle.

Top module: `route_cam_unit`

## Requirements
- R1: Entry i matches a key when its valid flag is 1 and, for every bit position b, either mask bit b is 1 (don't-care) or pattern bit b equals key bit b. An entry whose mask is all ones matches every key.
- R2: When several entries match, the entry with the lowest index is reported, and at most one entry is ever selected.
- R3: An entry whose valid flag is 0 never matches, whatever its pattern and mask.
- R4: On a hit, `res_hit` is 1, `res_index` holds the winning entry index, and `res_port` holds the port stored for that entry.
- R5: On a miss, `res_hit` is 0, `res_index` is 0, and `res_port` holds the default port that was in force when the key entered.
- R6: `res_valid` is high exactly two clock edges after a cycle in which `lk_valid` was high. Keys may be presented on every cycle with no gaps.
- R7: A lookup presented in the same cycle as a host write sees the table as it was before the write. A lookup presented in any later cycle sees the written value.
- R8: A refresh rewrite takes place at most once every REFRESH_INTERVAL cycles and only in a cycle with no host write. It moves to the next entry in round-robin order, leaves the stored contents unchanged, and never stalls or alters a lookup.
- R9: After synchronous reset, `res_valid` is 0, every entry is invalid, and the default port is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A routing key is presented this cycle |
| lk_key | input | KEY_W | Routing key (destination field concatenated with current-node field) |
| wr_en | input | 1 | Host writes one whole entry this cycle |
| wr_idx | input | IDX_W | Entry index being written |
| wr_pattern | input | KEY_W | Pattern to store |
| wr_mask | input | KEY_W | Don't-care mask to store (1 = ignore the bit) |
| wr_valid | input | 1 | Valid flag to store |
| wr_port | input | PORT_W | Output port assigned to the entry |
| dflt_wr_en | input | 1 | Load a new default port |
| dflt_port | input | PORT_W | Default port value for misses |
| res_valid | output | 1 | A routing decision is presented |
| res_hit | output | 1 | 1 when some entry matched |
| res_index | output | IDX_W | Winning entry index (0 on a miss) |
| res_port | output | PORT_W | Selected output port |

## Verification
The bound checker covers four properties on every cycle. It checks the two-edge latency and that no key is ever stalled. It checks that the resolver selects at most one entry and that the selected entry was valid when its key was compared. It also checks that a miss reports index 0, and that each refresh rewrite advances the pointer and leaves the table contents unchanged. Some behaviour can only be shown by the bench's scenarios against its own table model. This covers which entry wins when masks overlap, that an all-ones mask matches any key, and that invalid entries stay silent. It also covers the old-then-new visibility of writes made back-to-back with lookups, and that results stay correct over a long mixed stream while refresh runs underneath.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    localparam int unsigned RCU_ENTRIES          = 8;
    localparam int unsigned RCU_KEY_W            = 16;
    localparam int unsigned RCU_PORTS            = 8;
    localparam int unsigned RCU_REFRESH_INTERVAL = 64;

    // Owner of the single table write port in a given cycle.
    typedef enum logic [1:0] {
        WSRC_IDLE    = 2'd0,
        WSRC_HOST    = 2'd1,
        WSRC_REFRESH = 2'd2
    } wsrc_e;

    // Index width with a floor of one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rcu_cam_array.sv
module rcu_cam_array #(
    parameter int unsigned ENTRIES = rcu_pkg::RCU_ENTRIES,
    parameter int unsigned KEY_W   = rcu_pkg::RCU_KEY_W,
    parameter int unsigned IDX_W   = rcu_pkg::idx_bits(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 widx,
    input  logic [KEY_W-1:0]                 wpat,
    input  logic [KEY_W-1:0]                 wmsk,
    input  logic                             wvld,
    input  logic [KEY_W-1:0]                 key,
    input  logic [IDX_W-1:0]                 ridx,
    output logic [KEY_W-1:0]                 rpat,
    output logic [KEY_W-1:0]                 rmsk,
    output logic                             rvld,
    output logic [ENTRIES-1:0]               match,
    output logic [ENTRIES-1:0]               vld_vec,
    output logic [ENTRIES*(2*KEY_W+1)-1:0]   flat
);
    localparam int unsigned SLOT_W = 2 * KEY_W + 1;

    logic [KEY_W-1:0] pat_q [ENTRIES];
    logic [KEY_W-1:0] msk_q [ENTRIES];
    logic             vld_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                pat_q[i] <= '0;
                msk_q[i] <= '0;
                vld_q[i] <= 1'b0;
            end
        end else if (we) begin
            pat_q[widx] <= wpat;
            msk_q[widx] <= wmsk;
            vld_q[widx] <= wvld;
        end
    end

    // One comparator per entry; masked bits drop out of the compare.
    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_cmp
        logic [KEY_W-1:0] diff;
        assign diff       = (pat_q[g] ^ key) & ~msk_q[g];
        assign match[g]   = vld_q[g] && (diff == '0);
        assign vld_vec[g] = vld_q[g];
        assign flat[g*SLOT_W +: SLOT_W] = {vld_q[g], msk_q[g], pat_q[g]};
    end

    assign rpat = pat_q[ridx];
    assign rmsk = msk_q[ridx];
    assign rvld = vld_q[ridx];

endmodule

// File: rtl/rcu_port_table.sv
module rcu_port_table #(
    parameter int unsigned ENTRIES = rcu_pkg::RCU_ENTRIES,
    parameter int unsigned PORT_W  = 3,
    parameter int unsigned IDX_W   = rcu_pkg::idx_bits(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [PORT_W-1:0]           wport,
    input  logic                        dflt_we,
    input  logic [PORT_W-1:0]           dflt_in,
    input  logic [IDX_W-1:0]            ridx,
    output logic [PORT_W-1:0]           rport,
    output logic [ENTRIES*PORT_W-1:0]   ports_flat,
    output logic [PORT_W-1:0]           dflt
);
    logic [PORT_W-1:0] port_q [ENTRIES];
    logic [PORT_W-1:0] dflt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                port_q[i] <= '0;
            end
            dflt_q <= '0;
        end else begin
            if (we) begin
                port_q[widx] <= wport;
            end
            if (dflt_we) begin
                dflt_q <= dflt_in;
            end
        end
    end

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_flat
        assign ports_flat[g*PORT_W +: PORT_W] = port_q[g];
    end

    assign rport = port_q[ridx];
    assign dflt  = dflt_q;

endmodule

// File: rtl/rcu_refresh.sv
module rcu_refresh #(
    parameter int unsigned ENTRIES  = rcu_pkg::RCU_ENTRIES,
    parameter int unsigned INTERVAL = rcu_pkg::RCU_REFRESH_INTERVAL,
    parameter int unsigned IDX_W    = rcu_pkg::idx_bits(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_busy,
    output logic             fire,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned CNT_W = rcu_pkg::idx_bits(INTERVAL);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [IDX_W-1:0] ptr_q;
    logic             tick;

    assign tick = (cnt_q == CNT_LAST);
    // A due rewrite waits for a cycle in which the host leaves the port free.
    assign fire = pend_q && !host_busy;
    assign idx  = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (tick) begin
                pend_q <= 1'b1;
            end else if (fire) begin
                pend_q <= 1'b0;
            end
            if (fire) begin
                ptr_q <= (ptr_q == IDX_LAST) ? '0 : ptr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcu_prio.sv
module rcu_prio #(
    parameter int unsigned ENTRIES = rcu_pkg::RCU_ENTRIES,
    parameter int unsigned IDX_W   = rcu_pkg::idx_bits(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic [ENTRIES-1:0] grant,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    logic [ENTRIES:0] seen;

    assign seen[0] = 1'b0;
    // Lower index wins: a request is granted only if nothing below it asked.
    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_chain
        assign grant[g]  = req[g] && !seen[g];
        assign seen[g+1] = seen[g] || req[g];
    end

    assign hit = seen[ENTRIES];

    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/route_cam_unit.sv
module route_cam_unit #(
    parameter int unsigned ENTRIES          = rcu_pkg::RCU_ENTRIES,
    parameter int unsigned KEY_W            = rcu_pkg::RCU_KEY_W,
    parameter int unsigned PORTS            = rcu_pkg::RCU_PORTS,
    parameter int unsigned REFRESH_INTERVAL = rcu_pkg::RCU_REFRESH_INTERVAL,
    localparam int unsigned IDX_W           = rcu_pkg::idx_bits(ENTRIES),
    localparam int unsigned PORT_W          = rcu_pkg::idx_bits(PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_pattern,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic              wr_valid,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              dflt_wr_en,
    input  logic [PORT_W-1:0] dflt_port,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_index,
    output logic [PORT_W-1:0] res_port
);
    import rcu_pkg::*;

    localparam int unsigned SLOT_W = 2 * KEY_W + 1;

    typedef struct packed {
        logic                      v;
        logic [ENTRIES-1:0]        m;
        logic [ENTRIES*PORT_W-1:0] ports;
        logic [PORT_W-1:0]         dflt;
    } stage1_t;

    typedef struct packed {
        logic              v;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [PORT_W-1:0] port;
    } result_t;

    // ---------------- shared write port ----------------
    wsrc_e             wsrc;
    logic              rf_fire;
    logic [IDX_W-1:0]  rf_idx;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_widx;
    logic [KEY_W-1:0]  tbl_wpat;
    logic [KEY_W-1:0]  tbl_wmsk;
    logic              tbl_wvld;
    logic [PORT_W-1:0] tbl_wport;

    logic [KEY_W-1:0]  rd_pat;
    logic [KEY_W-1:0]  rd_msk;
    logic              rd_vld;
    logic [PORT_W-1:0] rd_port;

    always_comb begin
        if (wr_en) begin
            wsrc = WSRC_HOST;
        end else if (rf_fire) begin
            wsrc = WSRC_REFRESH;
        end else begin
            wsrc = WSRC_IDLE;
        end
    end

    always_comb begin
        tbl_we    = 1'b0;
        tbl_widx  = wr_idx;
        tbl_wpat  = wr_pattern;
        tbl_wmsk  = wr_mask;
        tbl_wvld  = wr_valid;
        tbl_wport = wr_port;
        unique case (wsrc)
            WSRC_HOST: begin
                tbl_we = 1'b1;
            end
            WSRC_REFRESH: begin
                tbl_we    = 1'b1;
                tbl_widx  = rf_idx;
                tbl_wpat  = rd_pat;
                tbl_wmsk  = rd_msk;
                tbl_wvld  = rd_vld;
                tbl_wport = rd_port;
            end
            default: begin
                tbl_we = 1'b0;
            end
        endcase
    end

    rcu_refresh #(
        .ENTRIES (ENTRIES),
        .INTERVAL(REFRESH_INTERVAL),
        .IDX_W   (IDX_W)
    ) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .host_busy(wr_en),
        .fire     (rf_fire),
        .idx      (rf_idx)
    );

    // ---------------- storage ----------------
    logic [ENTRIES-1:0]         cam_match;
    logic [ENTRIES-1:0]         ent_valid;
    logic [ENTRIES*SLOT_W-1:0]  cam_flat;
    logic [ENTRIES*PORT_W-1:0]  port_flat;
    logic [PORT_W-1:0]          dflt_cur;

    rcu_cam_array #(
        .ENTRIES(ENTRIES),
        .KEY_W  (KEY_W),
        .IDX_W  (IDX_W)
    ) u_cam (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .widx   (tbl_widx),
        .wpat   (tbl_wpat),
        .wmsk   (tbl_wmsk),
        .wvld   (tbl_wvld),
        .key    (lk_key),
        .ridx   (rf_idx),
        .rpat   (rd_pat),
        .rmsk   (rd_msk),
        .rvld   (rd_vld),
        .match  (cam_match),
        .vld_vec(ent_valid),
        .flat   (cam_flat)
    );

    rcu_port_table #(
        .ENTRIES(ENTRIES),
        .PORT_W (PORT_W),
        .IDX_W  (IDX_W)
    ) u_ports (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .widx      (tbl_widx),
        .wport     (tbl_wport),
        .dflt_we   (dflt_wr_en),
        .dflt_in   (dflt_port),
        .ridx      (rf_idx),
        .rport     (rd_port),
        .ports_flat(port_flat),
        .dflt      (dflt_cur)
    );

    // ---------------- stage 1: compare + port snapshot ----------------
    stage1_t s1_q;
    logic    s1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.v     <= lk_valid;
            s1_q.m     <= lk_valid ? cam_match : '0;
            s1_q.ports <= port_flat;
            s1_q.dflt  <= dflt_cur;
        end
    end

    assign s1_valid = s1_q.v;

    // ---------------- stage 2: resolve + select ----------------
    logic [ENTRIES-1:0] s2_grant;
    logic               s2_hit;
    logic [IDX_W-1:0]   s2_idx;
    result_t            res_d;
    result_t            res_q;

    rcu_prio #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_prio (
        .req  (s1_q.m),
        .grant(s2_grant),
        .hit  (s2_hit),
        .idx  (s2_idx)
    );

    always_comb begin
        res_d.v    = s1_q.v;
        res_d.hit  = s1_q.v && s2_hit;
        res_d.idx  = res_d.hit ? s2_idx : '0;
        res_d.port = res_d.hit ? s1_q.ports[s2_idx*PORT_W +: PORT_W] : s1_q.dflt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.v;
    assign res_hit   = res_q.hit;
    assign res_index = res_q.idx;
    assign res_port  = res_q.port;

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned IDX_W   = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           lk_valid,
    input logic                           s1_valid,
    input logic [ENTRIES-1:0]             s1_match,
    input logic                           res_valid,
    input logic                           res_hit,
    input logic [IDX_W-1:0]               res_index,
    input logic [ENTRIES-1:0]             grant,
    input logic [ENTRIES-1:0]             entry_valid,
    input logic                           rf_fire,
    input logic [IDX_W-1:0]               rf_idx,
    input logic [ENTRIES*(2*KEY_W+1)-1:0] cam_flat
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R6
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (res_valid == $past(lk_valid, 2)));

    // R6
    no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> s1_valid);

    // R2
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    invalid_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q != 2'd0) |-> ((s1_match & ~$past(entry_valid)) == '0));

    // R5
    miss_index_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_index == '0));

    // R8
    refresh_step_chk: assert property (@(posedge clk) disable iff (rst)
        rf_fire |=> (rf_idx == (($past(rf_idx) == IDX_LAST) ? '0 : $past(rf_idx) + 1'b1)));

    // R8
    refresh_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rf_fire |=> $stable(cam_flat));

endmodule

bind route_cam_unit rcu_checker #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .s1_valid   (s1_valid),
    .s1_match   (s1_q.m),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_index  (res_index),
    .grant      (s2_grant),
    .entry_valid(ent_valid),
    .rf_fire    (rf_fire),
    .rf_idx     (rf_idx),
    .cam_flat   (cam_flat)
);

// File: tb/route_cam_unit_test.sv
module route_cam_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int KEY_W      = 16;
    localparam int PORTS      = 8;
    localparam int RINT       = 4;
    localparam int IDX_W      = 3;
    localparam int PORT_W     = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [KEY_W-1:0]  lk_key = '0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [KEY_W-1:0]  wr_pattern = '0;
    logic [KEY_W-1:0]  wr_mask = '0;
    logic              wr_valid = 1'b0;
    logic [PORT_W-1:0] wr_port = '0;
    logic              dflt_wr_en = 1'b0;
    logic [PORT_W-1:0] dflt_port = '0;
    logic              res_valid;
    logic              res_hit;
    logic [IDX_W-1:0]  res_index;
    logic [PORT_W-1:0] res_port;

    always #(CLK_PERIOD/2) clk = ~clk;

    route_cam_unit #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .PORTS(PORTS), .REFRESH_INTERVAL(RINT)
    ) uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_key(lk_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pattern(wr_pattern), .wr_mask(wr_mask),
        .wr_valid(wr_valid), .wr_port(wr_port), .dflt_wr_en(dflt_wr_en),
        .dflt_port(dflt_port), .res_valid(res_valid), .res_hit(res_hit),
        .res_index(res_index), .res_port(res_port)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R9";

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        bit v;
        bit hit;
        int idx;
        int port;
    } exp_t;

    logic [KEY_W-1:0] m_pat  [ENTRIES];
    logic [KEY_W-1:0] m_msk  [ENTRIES];
    bit               m_vld  [ENTRIES];
    int               m_port [ENTRIES];
    int               m_dflt;
    exp_t             pipe_q [$];

    always @(posedge clk) begin
        exp_t e;
        e.v = 0; e.hit = 0; e.idx = 0; e.port = 0;
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                m_vld[i] = 0; m_pat[i] = '0; m_msk[i] = '0; m_port[i] = 0;
            end
            m_dflt = 0;
        end else begin
            if (lk_valid) begin
                e.v = 1;
                e.port = m_dflt;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (m_vld[i] && (((lk_key ^ m_pat[i]) & ~m_msk[i]) == '0)) begin
                        e.hit = 1; e.idx = i; e.port = m_port[i];
                    end
                end
            end
            if (wr_en) begin
                m_pat[wr_idx] = wr_pattern;
                m_msk[wr_idx] = wr_mask;
                m_vld[wr_idx] = wr_valid;
                m_port[wr_idx] = int'(wr_port);
            end
            if (dflt_wr_en) m_dflt = int'(dflt_port);
        end
        pipe_q.push_back(e);
        if (pipe_q.size() > 2) void'(pipe_q.pop_front());
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && pipe_q.size() == 2) begin
            exp_t e;
            e = pipe_q[0];
            check("R6", int'(res_valid), int'(e.v), "res_valid");
            if (e.v) begin
                check(cur_req, int'(res_hit), int'(e.hit), "res_hit");
                check(cur_req, int'(res_index), e.idx, "res_index");
                check(cur_req, int'(res_port), e.port, "res_port");
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit lv, input logic [KEY_W-1:0] key,
                         input bit we, input int idx, input logic [KEY_W-1:0] pat,
                         input logic [KEY_W-1:0] msk, input bit vld, input int port,
                         input bit dwe, input int dport);
        @(negedge clk);
        lk_valid   = lv;
        lk_key     = key;
        wr_en      = we;
        wr_idx     = IDX_W'(idx);
        wr_pattern = pat;
        wr_mask    = msk;
        wr_valid   = vld;
        wr_port    = PORT_W'(port);
        dflt_wr_en = dwe;
        dflt_port  = PORT_W'(dport);
    endtask

    task automatic look(input logic [KEY_W-1:0] key);
        drive(1, key, 0, 0, '0, '0, 0, 0, 0, 0);
    endtask

    task automatic put(input int idx, input logic [KEY_W-1:0] pat,
                       input logic [KEY_W-1:0] msk, input bit vld, input int port);
        drive(0, '0, 1, idx, pat, msk, vld, port, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0, '0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state visible at the ports
        check("R9", int'(res_valid), 0, "res_valid after reset");
        cur_req = "R9";
        look(16'hABCD);           // miss, default port 0 after reset
        idle(3);

        // R4: exact entry
        cur_req = "R4";
        put(3, 16'h1234, 16'h0000, 1, 5);
        look(16'h1234);
        idle(3);
        // R1: one differing unmasked bit misses
        cur_req = "R1";
        look(16'h1235);
        put(1, 16'h1200, 16'h00FF, 1, 2);
        look(16'h12AB);           // masked low byte ignored
        idle(3);
        // R2: entries 1 and 3 both match 0x1234, entry 1 wins
        cur_req = "R2";
        look(16'h1234);
        put(6, 16'h0000, 16'hFFFF, 1, 4);
        look(16'h1234);           // 1,3,6 match -> 1
        look(16'h5555);           // only 6 -> 6
        idle(3);
        // R3: all-masked but invalid entry stays silent
        cur_req = "R3";
        put(6, 16'h0000, 16'hFFFF, 0, 4);
        put(0, 16'h0000, 16'hFFFF, 0, 7);
        look(16'h9999);
        idle(3);
        // R5: miss returns programmed default port
        cur_req = "R5";
        drive(0, '0, 0, 0, '0, '0, 0, 0, 1, 6);
        look(16'h9999);
        look(16'h1299);           // hit entry 1 for contrast
        idle(3);
        // R1: all-ones mask, valid, matches every key
        cur_req = "R1";
        put(0, 16'h0F0F, 16'hFFFF, 1, 7);
        look(16'h9999);
        look(16'h0000);
        idle(3);
        // R7: write in same cycle as lookup sees old, next cycle sees new
        cur_req = "R7";
        drive(1, 16'h1234, 1, 0, '0, '0, 0, 0, 0, 0);   // old: entry 0 hits
        look(16'h1234);                                  // new: entry 1 hits
        drive(1, 16'h1234, 1, 1, '0, '0, 0, 0, 0, 0);   // old: entry 1
        drive(1, 16'h1234, 0, 0, '0, '0, 0, 0, 1, 3);   // new: entry 3; default write
        drive(1, 16'h7777, 0, 0, '0, '0, 0, 0, 0, 0);   // miss sees default 3
        idle(3);

        // R8: long back-to-back stream with refresh running and random writes
        cur_req = "R8";
        for (int c = 0; c < 600; c++) begin
            logic [KEY_W-1:0] k;
            bit we;
            k  = KEY_W'($urandom) & 16'h0F3F;
            we = ($urandom % 6) == 0;
            drive(1, k, we, int'($urandom % ENTRIES),
                  KEY_W'($urandom) & 16'h0F3F, KEY_W'($urandom) & KEY_W'($urandom),
                  ($urandom % 4) != 0, int'($urandom % PORTS),
                  ($urandom % 20) == 0, int'($urandom % PORTS));
        end
        idle(4);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule